// File: doc/BRIEF.md
# I2C Master Interrupt Status and Clear Unit

This block collects the twelve event sources of an I2C master controller into a raw status register. It combines that register with a software-written enable mask and drives one interrupt line. Software reads either the raw status or the masked status through a small register port. It acknowledges an event by reading the clear register dedicated to that event, which leaves every other pending event untouched. A second register clears all pulse-type events in one read.

When a transfer aborts, the controller pulses the abort event together with a reason vector. The unit ORs the reasons into an abort-reason register. Software must read that register before it acknowledges the abort, because the acknowledge read also empties the reason register. The receive-full and transmit-empty sources are levels that follow FIFO state, so reads never clear them.

All register reads are combinational from stored state, and every clear takes effect at the clock edge that ends the read cycle. The data returned by a read is therefore the state before that clear.

Top module: `i2c_irq_unit`

## Requirements
- R1: Status bit positions are fixed: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 transfer abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A one-cycle pulse on `evt[n]` sets raw bit n at that clock edge. For the pulse sources (all bits except 2 and 4), the bit then holds until it is cleared.
- R2: A read of offset 0x2C returns the raw status ANDed with the mask. A read of offset 0x34 returns the raw status. Both values appear in bits 11:0.
- R3: A read of a dedicated clear register clears only its own source. The pulse sources, in ascending bit order (0,1,3,5,6,7,8,9,10,11), map to offsets 0x44, 0x48, … 0x68 at a stride of 4.
- R4: A read of offset 0x40 clears every pulse source at once.
- R5: When `evt[6]` pulses, the bits of `abortWhy` are ORed into the abort-reason register, read at offset 0x80. Reason bits 6 and 8 are reserved and never stored. The valid reasons are: 0 7-bit address nack, 1 first 10-bit address byte nack, 2 second 10-bit byte nack, 3 data nack, 4 general call nack, 5 read after general call, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 use while disabled, 12 arbitration lost.
- R6: A read of the abort clear register (0x54) or of the combined clear register (0x40) also empties the abort-reason register.
- R7: An event that arrives in the same cycle as a read that clears it stays set. If that event is the abort, only the reasons that arrive with it remain.
- R8: Raw bits 2 and 4 copy `evt[2]` and `evt[4]` one cycle later, and no clear read changes them.
- R9: `irq` is high exactly when some masked status bit is set.
- R10: After reset the raw status, the mask and the abort reasons are zero. Only a write to offset 0x30 changes the mask, loading it from `wrData`. Writes to any other offset have no effect.
- R11: A read of a dedicated clear register returns the pre-clear state of its source in bit 0. A read of the combined clear register returns in bit 0 the OR of all pulse-source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evt | input | 12 | Event pulses; bits 2 and 4 are held levels |
| abortWhy | input | 13 | Abort reasons, sampled with `evt[6]` |
| rdEn | input | 1 | Register read strobe (clears take effect at the edge) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 12 | Write data (mask) |
| rdData | output | 32 | Read data for the current cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is an event that collides with its own clear read. For the abort source, the stored reasons must also be replaced rather than merged during that collision. The stimulus places an abort pulse with a fresh reason in the same cycle as the abort clear read. It then reads back both the status and the reason register. It repeats the collision with the combined clear and an unrelated stop event. The level sources are held high across a combined clear to show that the read cannot drop them.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NumSrc = 12;
  localparam int AbrtW  = 13;
  localparam int DataW  = 32;
  localparam int AddrW  = 8;
  localparam int BitAbort = 6;

  localparam logic [NumSrc-1:0] LevelSrc = 12'h014;
  localparam logic [NumSrc-1:0] ClrAble  = ~LevelSrc;
  localparam logic [AbrtW-1:0]  AbrtValid = 13'h1EBF;

  localparam logic [AddrW-1:0] OffMasked  = 8'h2C;
  localparam logic [AddrW-1:0] OffMask    = 8'h30;
  localparam logic [AddrW-1:0] OffRaw     = 8'h34;
  localparam logic [AddrW-1:0] OffClrAll  = 8'h40;
  localparam logic [AddrW-1:0] OffClrBase = 8'h44;
  localparam logic [AddrW-1:0] OffAbrt    = 8'h80;

  typedef enum logic [2:0] {
    SelNone, SelMasked, SelMask, SelRaw, SelAbrt, SelClr
  } rdsel_e;

  typedef struct packed {
    logic [NumSrc-1:0] clrSrc;
    logic              clrAbrt;
    logic              maskWr;
    rdsel_e            rdSel;
  } strobe_t;

  // Offset of the dedicated clear register of source n: pulse sources only,
  // packed in ascending bit order at a 4-byte stride.
  function automatic logic [AddrW-1:0] clrOffset(input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < NumSrc; i++)
      if (i < n && ClrAble[i]) cnt++;
    return OffClrBase + AddrW'(4 * cnt);
  endfunction
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
(
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  output strobe_t          st
);
  logic [NumSrc-1:0] clrHit;

  for (genvar n = 0; n < NumSrc; n++) begin : g_hit
    if (ClrAble[n]) begin : g_pulse
      assign clrHit[n] = (addr == clrOffset(n));
    end else begin : g_level
      assign clrHit[n] = 1'b0;
    end
  end

  always_comb begin
    st = '0;
    st.rdSel = SelNone;
    st.maskWr = wrEn && (addr == OffMask);
    if (rdEn) begin
      case (addr)
        OffMasked: st.rdSel = SelMasked;
        OffMask:   st.rdSel = SelMask;
        OffRaw:    st.rdSel = SelRaw;
        OffAbrt:   st.rdSel = SelAbrt;
        OffClrAll: begin
          st.clrSrc = ClrAble;
          st.rdSel  = SelClr;
        end
        default: begin
          if (|clrHit) begin
            st.clrSrc = clrHit;
            st.rdSel  = SelClr;
          end
        end
      endcase
    end
    st.clrAbrt = st.clrSrc[BitAbort];
  end
endmodule

// File: rtl/i2c_irq_store.sv
module i2c_irq_store
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] evt,
  input  logic [AbrtW-1:0]  abortWhy,
  input  logic [NumSrc-1:0] wrData,
  input  strobe_t           st,
  output logic [NumSrc-1:0] rawStat,
  output logic [NumSrc-1:0] maskReg,
  output logic [AbrtW-1:0]  abrtSrc,
  output logic [DataW-1:0]  rdData,
  output logic              irq
);
  logic [NumSrc-1:0] maskedStat;
  logic [AbrtW-1:0]  abrtKeep;

  assign maskedStat = rawStat & maskReg;
  assign abrtKeep   = st.clrAbrt ? '0 : abrtSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawStat <= '0;
      maskReg <= '0;
      abrtSrc <= '0;
    end else begin
      rawStat <= (LevelSrc & evt) |
                 (ClrAble & (evt | (rawStat & ~st.clrSrc)));
      if (st.maskWr) maskReg <= wrData;
      if (evt[BitAbort]) abrtSrc <= abrtKeep | (abortWhy & AbrtValid);
      else               abrtSrc <= abrtKeep;
    end
  end

  always_comb begin
    case (st.rdSel)
      SelMasked: rdData = DataW'(maskedStat);
      SelMask:   rdData = DataW'(maskReg);
      SelRaw:    rdData = DataW'(rawStat);
      SelAbrt:   rdData = DataW'(abrtSrc);
      SelClr:    rdData = DataW'(|(rawStat & st.clrSrc));
      default:   rdData = '0;
    endcase
  end

  assign irq = |maskedStat;
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] evt,
  input  logic [AbrtW-1:0]  abortWhy,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [AddrW-1:0]  addr,
  input  logic [NumSrc-1:0] wrData,
  output logic [DataW-1:0]  rdData,
  output logic              irq
);
  strobe_t           st;
  logic [NumSrc-1:0] rawStat;
  logic [NumSrc-1:0] maskReg;
  logic [AbrtW-1:0]  abrtSrc;

  i2c_irq_decode u_decode (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .st   (st)
  );

  i2c_irq_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .abortWhy (abortWhy),
    .wrData   (wrData),
    .st       (st),
    .rawStat  (rawStat),
    .maskReg  (maskReg),
    .abrtSrc  (abrtSrc),
    .rdData   (rdData),
    .irq      (irq)
  );
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NumSrc-1:0] evt,
  input logic              rdEn,
  input logic              wrEn,
  input logic [AddrW-1:0]  addr,
  input logic [DataW-1:0]  rdData,
  input logic              irq,
  input logic [NumSrc-1:0] raw,
  input logic [NumSrc-1:0] mask,
  input logic [AbrtW-1:0]  abrt
);
  for (genvar n = 0; n < NumSrc; n++) begin : g_src
    if (ClrAble[n]) begin : g_pulse
      // R3
      clr_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        (rdEn && addr == clrOffset(n) && !evt[n])
          |=> (!raw[n] && ((raw & ~(NumSrc'(1) << n)) ==
                           ($past(raw) & ~(NumSrc'(1) << n)) | ($past(evt) & ~(NumSrc'(1) << n)))));
    end
  end

  // R6
  abrt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == clrOffset(BitAbort) || addr == OffClrAll) && !evt[BitAbort])
      |=> (abrt == '0));

  // R7
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(evt & ClrAble)) |=> ((raw & $past(evt & ClrAble)) == $past(evt & ClrAble)));

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> ((raw & LevelSrc) == ($past(evt) & LevelSrc)));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OffMasked) |-> (irq == (rdData != '0)));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == OffMask) |=> $stable(mask));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .evt    (evt),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .addr   (addr),
  .rdData (rdData),
  .irq    (irq),
  .raw    (rawStat),
  .mask   (maskReg),
  .abrt   (abrtSrc)
);

// File: tb/i2c_irq_unit_bench.sv
module i2c_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] evt = '0;
  logic [12:0] abortWhy = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [11:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2c_irq_unit u_i2c_irq_unit (
    .clk(clk), .rstN(rstN), .evt(evt), .abortWhy(abortWhy),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [7:0]  ad;
    logic [11:0] data;
    logic [11:0] ev;
    logic [12:0] ab;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NumVec = 20;
  localparam vec_t Tbl [NumVec] = '{
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h000, 4'd10}, // R10 raw reset
    '{1'b1, 1'b0, 8'h30, 12'h000, 12'h000, 13'h0000, 32'h000, 4'd10}, // R10 mask reset
    '{1'b0, 1'b1, 8'h30, 12'hFFF, 12'h000, 13'h0000, 32'h000, 4'd10},
    '{1'b0, 1'b0, 8'h00, 12'h000, 12'h001, 13'h0000, 32'h000, 4'd1},
    '{1'b0, 1'b0, 8'h00, 12'h000, 12'h840, 13'h1049, 32'h000, 4'd5},
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h841, 4'd1},  // R1
    '{1'b1, 1'b0, 8'h80, 12'h000, 12'h000, 13'h0000, 32'h1009, 4'd5}, // R5
    '{1'b1, 1'b0, 8'h2C, 12'h000, 12'h000, 13'h0000, 32'h841, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h30, 12'h040, 12'h000, 13'h0000, 32'h000, 4'd2},
    '{1'b1, 1'b0, 8'h2C, 12'h000, 12'h000, 13'h0000, 32'h040, 4'd2},  // R2
    '{1'b1, 1'b0, 8'h44, 12'h000, 12'h000, 13'h0000, 32'h001, 4'd11}, // R11
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h840, 4'd3},  // R3
    '{1'b1, 1'b0, 8'h54, 12'h000, 12'h000, 13'h0000, 32'h001, 4'd11}, // R11
    '{1'b1, 1'b0, 8'h80, 12'h000, 12'h000, 13'h0000, 32'h000, 4'd6},  // R6
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h800, 4'd3},  // R3
    '{1'b0, 1'b0, 8'h00, 12'h000, 12'h3A8, 13'h0000, 32'h000, 4'd1},
    '{1'b1, 1'b0, 8'h68, 12'h000, 12'h000, 13'h0000, 32'h001, 4'd11}, // R11
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h3A8, 4'd3},  // R3
    '{1'b1, 1'b0, 8'h40, 12'h000, 12'h000, 13'h0000, 32'h001, 4'd11}, // R11
    '{1'b1, 1'b0, 8'h34, 12'h000, 12'h000, 13'h0000, 32'h000, 4'd4}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one clock cycle.
  task automatic cyc(input logic [11:0] e, input logic [12:0] a, input logic r,
                     input logic w, input logic [7:0] ad, input logic [11:0] d,
                     output logic [31:0] rv, output logic iv);
    evt = e; abortWhy = a; rdEn = r; wrEn = w; addr = ad; wrData = d;
    #1;
    rv = rdData;
    iv = irq;
    @(posedge clk);
    @(negedge clk);
    evt = '0; abortWhy = '0; rdEn = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic        iv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R10 irq at reset", 32'(irq), 32'h0);

    for (int i = 0; i < NumVec; i++) begin
      cyc(Tbl[i].ev, Tbl[i].ab, Tbl[i].rd, Tbl[i].wr, Tbl[i].ad, Tbl[i].data, rv, iv);
      if (Tbl[i].rd) check($sformatf("R%0d table step %0d", Tbl[i].req, i), rv, Tbl[i].exp);
    end

    // mask is 0x040, raw and reasons empty
    cyc(12'h000, 13'h0, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    check("R9 irq idle", 32'(iv), 32'h0);
    cyc(12'h040, 13'h0001, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    cyc(12'h000, 13'h0, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    check("R9 irq on masked abort", 32'(iv), 32'h1);

    // R7: abort pulse collides with its own clear read
    cyc(12'h040, 13'h0800, 1'b1, 1'b0, 8'h54, 12'h0, rv, iv);
    check("R11 abort clear returns set", rv, 32'h1);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h80, 12'h0, rv, iv);
    check("R7 reasons replaced", rv, 32'h0800);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R7 abort kept", rv, 32'h040);

    // R7: stop event collides with combined clear; R6 combined clears reasons
    cyc(12'h200, 13'h0, 1'b1, 1'b0, 8'h40, 12'h0, rv, iv);
    check("R11 combined returns OR", rv, 32'h1);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R7 stop kept", rv, 32'h200);
    check("R9 unmasked source no irq", 32'(iv), 32'h0);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h80, 12'h0, rv, iv);
    check("R6 combined clears reasons", rv, 32'h0);

    // R8: level sources survive a combined clear
    cyc(12'h014, 13'h0, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    cyc(12'h014, 13'h0, 1'b1, 1'b0, 8'h40, 12'h0, rv, iv);
    cyc(12'h014, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R8 levels held through clear", rv, 32'h014);
    cyc(12'h000, 13'h0, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R8 levels follow input low", rv, 32'h0);

    // R10: write to a non-mask offset is ignored
    cyc(12'h000, 13'h0, 1'b0, 1'b1, 8'h34, 12'hFFF, rv, iv);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h30, 12'h0, rv, iv);
    check("R10 mask untouched", rv, 32'h040);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R10 raw untouched by write", rv, 32'h0);

    // R10: reset in mid-run
    cyc(12'h000, 13'h0, 1'b0, 1'b1, 8'h30, 12'hFFF, rv, iv);
    cyc(12'h841, 13'h0001, 1'b0, 1'b0, 8'h00, 12'h0, rv, iv);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h30, 12'h0, rv, iv);
    check("R10 mask after reset", rv, 32'h0);
    check("R10 irq after reset", 32'(iv), 32'h0);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h34, 12'h0, rv, iv);
    check("R10 raw after reset", rv, 32'h0);
    cyc(12'h000, 13'h0, 1'b1, 1'b0, 8'h80, 12'h0, rv, iv);
    check("R10 reasons after reset", rv, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule